// File: doc/BRIEF.md
# Sleep, Wake and Restart-Cause Controller

This block tracks whether the processor is running or halted and drives the enable that gates the system clock. A halt command stops the clock enable. The block then watches for four wake sources: an external reset, an interrupt request, a falling edge on any port A pin, and a watchdog time-out.

It decides which restart to issue, if any:
- a full reset, which reinitialises the whole device;
- a warm reset, which zeroes only the program counter and stack pointer;
- no reset at all, for an interrupt wake.

Two status flags record what happened, so software can work out after a restart why it is running again. The time-out flag records a watchdog expiry. The power-down flag records that a halt was entered.

The synchronous active-high reset input is the power-up reset. The external reset pin is active low and is treated as a level that is already synchronous to the clock. The block issues one full-reset pulse when that pin goes low. Port A pins are asynchronous and pass through a synchronizer before edge detection. All outputs are registered.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-up reset (rst high), clk_en_o is 1, both flags are 0, and neither reset output is asserted.
- R2: A halt command while running makes clk_en_o 0, pdn_flag_o 1 and tmo_flag_o 0 on the next cycle.
- R3: A clear-watchdog command while running clears pdn_flag_o on the next cycle and leaves tmo_flag_o unchanged.
- R4: A watchdog time-out pulse while running gives a one-cycle full_rst_o pulse on the next cycle and sets tmo_flag_o. clk_en_o stays 1 and pdn_flag_o is unchanged.
- R5: A watchdog time-out while halted gives a one-cycle warm_rst_o pulse with full_rst_o 0, sets tmo_flag_o, sets clk_en_o to 1, and leaves pdn_flag_o at 1.
- R6: A high-to-low change of ext_rst_n_i gives a one-cycle full_rst_o pulse on the next cycle, in both states. Both flags are left unchanged. When halted, clk_en_o also returns to 1.
- R7: An interrupt request while halted sets clk_en_o to 1 on the next cycle. No reset is issued and both flags are unchanged.
- R8: While halted, a falling edge on any port A pin (bit i of porta_i going 1 to 0) sets clk_en_o to 1 on the third clock edge after the pin changes. Falling edges while running, and rising edges while halted, have no effect.
- R9: Holding ext_rst_n_i low for several cycles gives only one full_rst_o pulse.
- R10: full_rst_o and warm_rst_o are never 1 together. When several events occur in the same cycle, the external reset outranks a watchdog time-out, which outranks a halt command or a wake event.
- R11: Halt and clear-watchdog commands are ignored while halted: clk_en_o stays 0 and pdn_flag_o stays 1.
- R12: An interrupt request while running has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-up reset, synchronous, active high |
| halt_cmd_i | input | 1 | One-cycle halt command |
| clrwd_cmd_i | input | 1 | One-cycle clear-watchdog command |
| wdt_tmo_i | input | 1 | One-cycle watchdog time-out pulse |
| ext_rst_n_i | input | 1 | External reset level, active low |
| irq_i | input | 1 | Interrupt request |
| porta_i | input | PA_W | Port A pins, asynchronous |
| clk_en_o | output | 1 | System clock enable |
| full_rst_o | output | 1 | Full reset pulse |
| warm_rst_o | output | 1 | Warm reset pulse (program counter and stack pointer only) |
| tmo_flag_o | output | 1 | Time-out status flag |
| pdn_flag_o | output | 1 | Power-down status flag |

## Verification
The hardest situation to reach from the ports is a port A edge that must be ignored because of the state it arrived in.

A falling edge that occurs while running must not linger and wake a later halt. The bench drives a pin low while running and holds it low. It then halts and confirms that the clock enable stays off for several cycles. It also drives a rising edge while halted to show that this does not wake the block either.

Exact wake latency through the synchronizer is checked both one cycle before and in the cycle the clock enable returns. Same-cycle collisions of the external reset with a watchdog time-out are driven to check the priority order and that the two reset outputs are never asserted together.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } pwr_state_t;

  typedef struct packed {
    logic set_tmo;
    logic clr_tmo;
    logic set_pdn;
    logic clr_pdn;
  } flag_cmd_t;

endpackage

// File: rtl/sleep_wake_edge.sv
module sleep_wake_edge #(
  parameter int PA_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PA_W-1:0] pins_i,
  output logic            fall_any_o
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [PA_W-1:0] fall_vec;

  genvar gi;
  generate
    for (gi = 0; gi < PA_W; gi++) begin : g_pin
      logic [SH_W-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SH_W-2:0], pins_i[gi]};
      end
      assign fall_vec[gi] = sh[SH_W-1] & ~sh[SH_W-2];
    end
  endgenerate

  assign fall_any_o = |fall_vec;

endmodule

// File: rtl/sleep_wake_fsm.sv
module sleep_wake_fsm
  import sleep_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      halt_cmd_i,
  input  logic      clrwd_cmd_i,
  input  logic      wdt_tmo_i,
  input  logic      ext_rst_n_i,
  input  logic      irq_i,
  input  logic      pin_fall_i,
  output logic      clk_en_o,
  output logic      full_rst_o,
  output logic      warm_rst_o,
  output flag_cmd_t fcmd_o
);

  pwr_state_t state_q, state_d;
  logic       ext_q;
  logic       ext_ev;
  logic       full_d, warm_d;
  logic       wake_ev;

  assign ext_ev  = ext_q & ~ext_rst_n_i;
  assign wake_ev = irq_i | pin_fall_i;

  always_comb begin
    state_d = state_q;
    full_d  = 1'b0;
    warm_d  = 1'b0;
    fcmd_o  = '0;
    if (state_q == ST_RUN) begin
      if (ext_ev) begin
        full_d = 1'b1;
      end else if (wdt_tmo_i) begin
        full_d         = 1'b1;
        fcmd_o.set_tmo = 1'b1;
      end else if (halt_cmd_i) begin
        state_d        = ST_HALT;
        fcmd_o.set_pdn = 1'b1;
        fcmd_o.clr_tmo = 1'b1;
      end else if (clrwd_cmd_i) begin
        fcmd_o.clr_pdn = 1'b1;
      end
    end else begin
      if (ext_ev) begin
        full_d  = 1'b1;
        state_d = ST_RUN;
      end else if (wdt_tmo_i) begin
        warm_d         = 1'b1;
        state_d        = ST_RUN;
        fcmd_o.set_tmo = 1'b1;
      end else if (wake_ev) begin
        state_d = ST_RUN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      ext_q      <= 1'b1;
      clk_en_o   <= 1'b1;
      full_rst_o <= 1'b0;
      warm_rst_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      ext_q      <= ext_rst_n_i;
      clk_en_o   <= (state_d == ST_RUN);
      full_rst_o <= full_d;
      warm_rst_o <= warm_d;
    end
  end

endmodule

// File: rtl/sleep_wake_flags.sv
module sleep_wake_flags
  import sleep_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_cmd_t fcmd_i,
  output logic      tmo_flag_o,
  output logic      pdn_flag_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_flag_o <= 1'b0;
      pdn_flag_o <= 1'b0;
    end else begin
      if (fcmd_i.set_tmo)      tmo_flag_o <= 1'b1;
      else if (fcmd_i.clr_tmo) tmo_flag_o <= 1'b0;
      if (fcmd_i.set_pdn)      pdn_flag_o <= 1'b1;
      else if (fcmd_i.clr_pdn) pdn_flag_o <= 1'b0;
    end
  end

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import sleep_wake_pkg::*;
#(
  parameter int PA_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            halt_cmd_i,
  input  logic            clrwd_cmd_i,
  input  logic            wdt_tmo_i,
  input  logic            ext_rst_n_i,
  input  logic            irq_i,
  input  logic [PA_W-1:0] porta_i,
  output logic            clk_en_o,
  output logic            full_rst_o,
  output logic            warm_rst_o,
  output logic            tmo_flag_o,
  output logic            pdn_flag_o
);

  logic      pin_fall;
  flag_cmd_t fcmd;

  sleep_wake_edge #(.PA_W(PA_W), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .pins_i     (porta_i),
    .fall_any_o (pin_fall)
  );

  sleep_wake_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .halt_cmd_i  (halt_cmd_i),
    .clrwd_cmd_i (clrwd_cmd_i),
    .wdt_tmo_i   (wdt_tmo_i),
    .ext_rst_n_i (ext_rst_n_i),
    .irq_i       (irq_i),
    .pin_fall_i  (pin_fall),
    .clk_en_o    (clk_en_o),
    .full_rst_o  (full_rst_o),
    .warm_rst_o  (warm_rst_o),
    .fcmd_o      (fcmd)
  );

  sleep_wake_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .fcmd_i     (fcmd),
    .tmo_flag_o (tmo_flag_o),
    .pdn_flag_o (pdn_flag_o)
  );

endmodule

// File: rtl/sleep_wake_ctrl_chk.sv
module sleep_wake_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic halt_cmd_i,
  input logic clrwd_cmd_i,
  input logic wdt_tmo_i,
  input logic ext_rst_n_i,
  input logic irq_i,
  input logic clk_en_o,
  input logic full_rst_o,
  input logic warm_rst_o,
  input logic tmo_flag_o,
  input logic pdn_flag_o
);

  p_no_dual_reset_r10: assert property (@(posedge clk) disable iff (rst)
    !(full_rst_o && warm_rst_o));

  p_warm_single_r5: assert property (@(posedge clk) disable iff (rst)
    warm_rst_o |=> !warm_rst_o);

  p_halt_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (clk_en_o && halt_cmd_i && !wdt_tmo_i && ext_rst_n_i)
    |=> (!clk_en_o && pdn_flag_o && !tmo_flag_o));

  p_halt_wdt_warm_r5: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_o && wdt_tmo_i && ext_rst_n_i)
    |=> (warm_rst_o && !full_rst_o && clk_en_o && tmo_flag_o));

  p_run_wdt_full_r4: assert property (@(posedge clk) disable iff (rst)
    (clk_en_o && wdt_tmo_i && ext_rst_n_i)
    |=> (full_rst_o && !warm_rst_o && clk_en_o && tmo_flag_o));

  p_clear_pdn_r3: assert property (@(posedge clk) disable iff (rst)
    (clk_en_o && clrwd_cmd_i && !halt_cmd_i && !wdt_tmo_i && ext_rst_n_i)
    |=> !pdn_flag_o);

  p_irq_wake_r7: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_o && irq_i && !wdt_tmo_i && ext_rst_n_i)
    |=> (clk_en_o && !full_rst_o && !warm_rst_o && $stable(pdn_flag_o)));

endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .halt_cmd_i  (halt_cmd_i),
  .clrwd_cmd_i (clrwd_cmd_i),
  .wdt_tmo_i   (wdt_tmo_i),
  .ext_rst_n_i (ext_rst_n_i),
  .irq_i       (irq_i),
  .clk_en_o    (clk_en_o),
  .full_rst_o  (full_rst_o),
  .warm_rst_o  (warm_rst_o),
  .tmo_flag_o  (tmo_flag_o),
  .pdn_flag_o  (pdn_flag_o)
);

// File: tb/sleep_wake_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_tb;

  localparam int PA_W = 8;

  logic            clk = 1'b0;
  logic            rst;
  logic            halt_cmd_i, clrwd_cmd_i, wdt_tmo_i, ext_rst_n_i, irq_i;
  logic [PA_W-1:0] porta_i;
  logic            clk_en_o, full_rst_o, warm_rst_o, tmo_flag_o, pdn_flag_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl #(.PA_W(PA_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .halt_cmd_i(halt_cmd_i), .clrwd_cmd_i(clrwd_cmd_i),
    .wdt_tmo_i(wdt_tmo_i), .ext_rst_n_i(ext_rst_n_i), .irq_i(irq_i),
    .porta_i(porta_i), .clk_en_o(clk_en_o), .full_rst_o(full_rst_o),
    .warm_rst_o(warm_rst_o), .tmo_flag_o(tmo_flag_o), .pdn_flag_o(pdn_flag_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_halt();
    halt_cmd_i = 1'b1; step(); halt_cmd_i = 1'b0;
  endtask

  task automatic pulse_wdt();
    wdt_tmo_i = 1'b1; step(); wdt_tmo_i = 1'b0;
  endtask

  task automatic pulse_irq();
    irq_i = 1'b1; step(); irq_i = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; halt_cmd_i = 0; clrwd_cmd_i = 0; wdt_tmo_i = 0;
    ext_rst_n_i = 1'b1; irq_i = 0; porta_i = '1;
    step(3);
    rst = 1'b0;
    step(4);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "clk_en", clk_en_o, 1'b1);
    chk("R1", "tmo", tmo_flag_o, 1'b0);
    chk("R1", "pdn", pdn_flag_o, 1'b0);
    chk("R1", "full", full_rst_o, 1'b0);
    chk("R1", "warm", warm_rst_o, 1'b0);
  endtask

  task automatic t_run_wdt_and_halt();
    do_reset();
    pulse_wdt();
    chk("R4", "full pulse", full_rst_o, 1'b1);
    chk("R4", "tmo set", tmo_flag_o, 1'b1);
    chk("R4", "clk_en", clk_en_o, 1'b1);
    chk("R4", "pdn", pdn_flag_o, 1'b0);
    step();
    chk("R4", "full one cycle", full_rst_o, 1'b0);
    pulse_halt();
    chk("R2", "clk_en off", clk_en_o, 1'b0);
    chk("R2", "pdn set", pdn_flag_o, 1'b1);
    chk("R2", "tmo cleared", tmo_flag_o, 1'b0);
    clrwd_cmd_i = 1'b1; halt_cmd_i = 1'b1; step();
    clrwd_cmd_i = 1'b0; halt_cmd_i = 1'b0; step();
    chk("R11", "pdn kept", pdn_flag_o, 1'b1);
    chk("R11", "still halted", clk_en_o, 1'b0);
  endtask

  task automatic t_irq_and_clear();
    do_reset();
    irq_i = 1'b1; step(2); irq_i = 1'b0;
    chk("R12", "clk_en", clk_en_o, 1'b1);
    chk("R12", "full", full_rst_o, 1'b0);
    chk("R12", "pdn", pdn_flag_o, 1'b0);
    pulse_halt();
    pulse_irq();
    chk("R7", "clk_en on", clk_en_o, 1'b1);
    chk("R7", "no full", full_rst_o, 1'b0);
    chk("R7", "no warm", warm_rst_o, 1'b0);
    chk("R7", "pdn kept", pdn_flag_o, 1'b1);
    chk("R7", "tmo kept", tmo_flag_o, 1'b0);
    pulse_wdt();
    step();
    clrwd_cmd_i = 1'b1; step(); clrwd_cmd_i = 1'b0;
    chk("R3", "pdn cleared", pdn_flag_o, 1'b0);
    chk("R3", "tmo kept", tmo_flag_o, 1'b1);
  endtask

  task automatic t_halt_wdt();
    do_reset();
    pulse_halt();
    pulse_wdt();
    chk("R5", "warm pulse", warm_rst_o, 1'b1);
    chk("R5", "no full", full_rst_o, 1'b0);
    chk("R5", "clk_en on", clk_en_o, 1'b1);
    chk("R5", "tmo set", tmo_flag_o, 1'b1);
    chk("R5", "pdn kept", pdn_flag_o, 1'b1);
    step();
    chk("R5", "warm one cycle", warm_rst_o, 1'b0);
  endtask

  task automatic t_ext_reset();
    do_reset();
    pulse_halt();
    pulse_irq();
    pulse_wdt();
    step();
    ext_rst_n_i = 1'b0; step();
    chk("R6", "full in run", full_rst_o, 1'b1);
    chk("R6", "tmo kept", tmo_flag_o, 1'b1);
    chk("R6", "pdn kept", pdn_flag_o, 1'b1);
    step();
    chk("R9", "single pulse", full_rst_o, 1'b0);
    step(3);
    chk("R9", "still single", full_rst_o, 1'b0);
    ext_rst_n_i = 1'b1; step(2);
    pulse_halt();
    ext_rst_n_i = 1'b0; step();
    chk("R6", "full in halt", full_rst_o, 1'b1);
    chk("R6", "wakes", clk_en_o, 1'b1);
    chk("R6", "pdn kept halt", pdn_flag_o, 1'b1);
    ext_rst_n_i = 1'b1; step(2);
    pulse_halt();
    ext_rst_n_i = 1'b0; wdt_tmo_i = 1'b1; step();
    wdt_tmo_i = 1'b0;
    chk("R10", "ext wins full", full_rst_o, 1'b1);
    chk("R10", "no warm", warm_rst_o, 1'b0);
    chk("R10", "tmo not set", tmo_flag_o, 1'b0);
    ext_rst_n_i = 1'b1; step(2);
  endtask

  task automatic t_porta();
    do_reset();
    pulse_halt();
    porta_i[2] = 1'b0;
    step(2);
    chk("R8", "not yet awake", clk_en_o, 1'b0);
    step();
    chk("R8", "awake on third edge", clk_en_o, 1'b1);
    chk("R8", "no reset", full_rst_o | warm_rst_o, 1'b0);
    porta_i = '1; step(4);
    porta_i[5] = 1'b0; step(4);
    chk("R8", "run fall ignored", clk_en_o, 1'b1);
    pulse_halt();
    step(4);
    chk("R8", "no stale wake", clk_en_o, 1'b0);
    porta_i[5] = 1'b1; step(4);
    chk("R8", "rise ignored", clk_en_o, 1'b0);
    pulse_irq();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_run_wdt_and_halt();
    t_irq_and_clear();
    t_halt_wdt();
    t_ext_reset();
    t_porta();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule